// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell Array

This block is the core of a small field-configurable logic device. Ten dedicated input bits and ten bidirectional pins feed a fixed AND array of 80 product terms over 40 literal columns. The product terms are split evenly among ten identical output macrocells, eight per macrocell. Each macrocell ORs four of its terms into the D input of a flip-flop. Its other four terms act as a reset, a preset, a clock and a per-pin output enable. The flip-flop drives its pin through an inverting buffer. When the reset and preset terms are both active, the flip-flop is bypassed and the pin is combinational.

The connection pattern of the array, 3200 bits, enters serially through a one-bit configuration port while a load-enable input is high. Two device-wide active-low controls act on every macrocell. One gates all pin drivers. The other loads all flip-flops that are not driving from the levels on their pins. All timing is referenced to one system clock: the clock product term is sampled on each system edge, and a 0-to-1 change counts as a clock edge for its macrocell.

Top module: `sopMacroArray`

## Requirements
- R1: While `cfgEn` is high and `rst` is low, one `cfgBit` is taken per clock. After 3200 such cycles, the k-th bit sent (counting from 0) is the connection bit of row k/40, column k%40.
- R2: Signal s drives column 2s in true form and column 2s+1 inverted. Signals 0–9 are `dedIn[0..9]`. Signal 10+k is the level of pin k: it is the inverse of macrocell k's flip-flop when `ioOe[k]` was high in the previous cycle, and `ioIn[k]` otherwise.
- R3: A product term is the AND of every literal whose connection bit is 1. A term with no connection bits set evaluates to 1.
- R4: Macrocell m owns rows 8m to 8m+7. Offsets 0–3 are data terms, offset 4 is reset, 5 is preset, 6 is clock and 7 is output enable.
- R5: With reset and preset both inactive, the flip-flop takes the OR of the data terms on a cycle where the clock term is 1 and was 0 in the previous cycle. Otherwise it holds. The pin value `ioOut[m]` is the inverse of the flip-flop.
- R6: If the reset term alone is active, the flip-flop is 0 after the edge and the pin reads 1. If the preset term alone is active, the flip-flop is 1 and the pin reads 0. Both terms override the clock term.
- R7: While the reset and preset terms are both active, `ioOut[m]` is the inverse of the data OR in the same cycle, and the flip-flop holds its value.
- R8: `ioOe[m]` is high only when the enable term is 1, `oeN` is low, and both `cfgEn` and `rst` are low.
- R9: When `preloadN` is low and `cfgEn` is low, every macrocell whose `ioOe` is low in that cycle loads the inverse of its `ioIn` bit. Driving macrocells hold. Preload takes priority over reset, preset and clock terms.
- R10: While loading, every flip-flop holds. After loading or reset, a clock term must be seen at 0 before a rising change is accepted.
- R11: A synchronous `rst` clears every flip-flop and every connection bit. While `rst` is high, no pin drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Configuration load enable |
| cfgBit | input | 1 | Serial connection bit |
| dedIn | input | 10 | Dedicated input signals |
| ioIn | input | 10 | Externally driven level of each bidirectional pin |
| oeN | input | 1 | Shared output enable, active low |
| preloadN | input | 1 | Shared register preload, active low |
| ioOut | output | 10 | Value presented to each bidirectional pin |
| ioOe | output | 10 | Drive enable of each bidirectional pin |

## Verification
The array is first tried with the cleared configuration. Every term is then 1, which tells the "no literal means true" rule apart from a default-false reading. Two loaded equation sets follow. The first uses dedicated inputs for the control roles, so that reset, preset, bypass, clock-edge and preload ordering can each be driven on its own. The second takes clocks and data from pin feedback, which separates the registered feedback path from the external pin path. Long stretches of random inputs under both sets compare every pin and enable against the reference on each cycle. These runs show whether bit order, column mapping or role offsets have been shuffled.

// File: rtl/sopPkg.sv
package sopPkg;
  localparam int DATA_TERMS   = 4;
  localparam int ROLE_RST     = 4;
  localparam int ROLE_PRE     = 5;
  localparam int ROLE_CLK     = 6;
  localparam int ROLE_OE      = 7;
  localparam int TERMS_PER_MC = 8;

  typedef struct packed {
    logic clearAll;
    logic shiftCfg;
    logic holdState;
    logic preloadGo;
    logic outAllow;
  } sopStrobe_t;
endpackage

// File: rtl/sopCtrl.sv
module sopCtrl
  import sopPkg::*;
(
  input  logic       rst,
  input  logic       cfgEn,
  input  logic       preloadN,
  input  logic       oeN,
  output sopStrobe_t strobes
);
  always_comb begin
    strobes.clearAll  = rst;
    strobes.shiftCfg  = cfgEn & ~rst;
    strobes.holdState = cfgEn & ~rst;
    strobes.preloadGo = ~preloadN & ~cfgEn & ~rst;
    strobes.outAllow  = ~oeN & ~cfgEn & ~rst;
  end
endmodule

// File: rtl/sopTermArray.sv
module sopTermArray #(
  parameter int NUM_ROW = 80,
  parameter int NUM_COL = 40
) (
  input  logic [NUM_ROW*NUM_COL-1:0] cfgBits,
  input  logic [NUM_COL-1:0]         colVals,
  output logic [NUM_ROW-1:0]         terms
);
  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    logic [NUM_COL-1:0] rowMask;
    assign rowMask  = cfgBits[r*NUM_COL +: NUM_COL];
    // unconnected literal forces a 1 into the AND
    assign terms[r] = &(~rowMask | colVals);
  end
endmodule

// File: rtl/sopMacrocell.sv
module sopMacrocell
  import sopPkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  sopStrobe_t            strobes,
  input  logic [DATA_TERMS-1:0] dataTerms,
  input  logic                  rstTerm,
  input  logic                  preTerm,
  input  logic                  clkTerm,
  input  logic                  oeTerm,
  input  logic                  padExt,
  output logic                  pinOut,
  output logic                  pinOe,
  output logic                  regQ
);
  logic q;
  logic clkPrev;
  logic dataSum;
  logic bypass;
  logic clkRise;

  assign dataSum = |dataTerms;
  assign bypass  = rstTerm & preTerm;
  assign clkRise = clkTerm & ~clkPrev;
  assign pinOe   = oeTerm & strobes.outAllow;
  assign pinOut  = bypass ? ~dataSum : ~q;
  assign regQ    = q;

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      q       <= 1'b0;
      clkPrev <= 1'b1;
    end else if (strobes.holdState) begin
      clkPrev <= 1'b1;
    end else begin
      clkPrev <= clkTerm;
      if (strobes.preloadGo) begin
        if (!pinOe) q <= ~padExt;
      end else if (!bypass) begin
        if (rstTerm)      q <= 1'b0;
        else if (preTerm) q <= 1'b1;
        else if (clkRise) q <= dataSum;
      end
    end
  end

  AST_LOAD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    strobes.holdState |=> $stable(q)); // R10
  AST_RESET_TERM: assert property (@(posedge clk) disable iff (rst)
    (!strobes.holdState && !strobes.preloadGo && rstTerm && !preTerm) |=> !q); // R6
  AST_PRESET_TERM: assert property (@(posedge clk) disable iff (rst)
    (!strobes.holdState && !strobes.preloadGo && preTerm && !rstTerm) |=> q); // R6
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.holdState && !strobes.preloadGo && rstTerm && preTerm) |=> $stable(q)); // R7
  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.holdState && !strobes.preloadGo && !rstTerm && !preTerm && !clkRise)
      |=> $stable(q)); // R5
  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strobes.preloadGo && !pinOe) |=> (q == !$past(padExt))); // R9
endmodule

// File: rtl/sopDatapath.sv
module sopDatapath
  import sopPkg::*;
#(
  parameter int NUM_DED = 10,
  parameter int NUM_MC  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  sopStrobe_t         strobes,
  input  logic               cfgBit,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_MC-1:0]  ioIn,
  output logic [NUM_MC-1:0]  ioOut,
  output logic [NUM_MC-1:0]  ioOe
);
  localparam int NUM_SIG  = NUM_DED + NUM_MC;
  localparam int NUM_COL  = 2 * NUM_SIG;
  localparam int NUM_ROW  = NUM_MC * TERMS_PER_MC;
  localparam int CFG_BITS = NUM_ROW * NUM_COL;

  logic [CFG_BITS-1:0] cfgBits;
  logic [NUM_MC-1:0]   oePrev;
  logic [NUM_MC-1:0]   regQ;
  logic [NUM_SIG-1:0]  sigVals;
  logic [NUM_COL-1:0]  colVals;
  logic [NUM_ROW-1:0]  terms;

  always_ff @(posedge clk) begin
    if (strobes.clearAll)      cfgBits <= '0;
    else if (strobes.shiftCfg) cfgBits <= {cfgBit, cfgBits[CFG_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) oePrev <= '0;
    else                  oePrev <= ioOe;
  end

  for (genvar s = 0; s < NUM_DED; s++) begin : g_ded
    assign sigVals[s] = dedIn[s];
  end
  for (genvar k = 0; k < NUM_MC; k++) begin : g_pad
    assign sigVals[NUM_DED+k] = oePrev[k] ? ~regQ[k] : ioIn[k];
  end
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_col
    assign colVals[2*s]   = sigVals[s];
    assign colVals[2*s+1] = ~sigVals[s];
  end

  sopTermArray #(.NUM_ROW(NUM_ROW), .NUM_COL(NUM_COL)) termArray_i (
    .cfgBits (cfgBits),
    .colVals (colVals),
    .terms   (terms)
  );

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    localparam int BASE = m * TERMS_PER_MC;
    sopMacrocell macrocell_i (
      .clk       (clk),
      .rst       (rst),
      .strobes   (strobes),
      .dataTerms (terms[BASE +: DATA_TERMS]),
      .rstTerm   (terms[BASE+ROLE_RST]),
      .preTerm   (terms[BASE+ROLE_PRE]),
      .clkTerm   (terms[BASE+ROLE_CLK]),
      .oeTerm    (terms[BASE+ROLE_OE]),
      .padExt    (ioIn[m]),
      .pinOut    (ioOut[m]),
      .pinOe     (ioOe[m]),
      .regQ      (regQ[m])
    );
  end

  AST_CLEAR_CFG: assert property (@(posedge clk)
    strobes.clearAll |=> (cfgBits == '0)); // R11
endmodule

// File: rtl/sopMacroArray.sv
module sopMacroArray
  import sopPkg::*;
#(
  parameter int NUM_DED = 10,
  parameter int NUM_MC  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgEn,
  input  logic               cfgBit,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_MC-1:0]  ioIn,
  input  logic               oeN,
  input  logic               preloadN,
  output logic [NUM_MC-1:0]  ioOut,
  output logic [NUM_MC-1:0]  ioOe
);
  sopStrobe_t strobes;

  sopCtrl ctrl_i (
    .rst      (rst),
    .cfgEn    (cfgEn),
    .preloadN (preloadN),
    .oeN      (oeN),
    .strobes  (strobes)
  );

  sopDatapath #(.NUM_DED(NUM_DED), .NUM_MC(NUM_MC)) datapath_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cfgBit  (cfgBit),
    .dedIn   (dedIn),
    .ioIn    (ioIn),
    .ioOut   (ioOut),
    .ioOe    (ioOe)
  );

  AST_QUIET_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfgEn |-> (ioOe == '0)); // R8
  AST_SHARED_OE: assert property (@(posedge clk) disable iff (rst)
    oeN |-> (ioOe == '0)); // R8
endmodule

// File: tb/sopMacroArray_tb_top.sv
`timescale 1ns/100ps
module sopMacroArray_tb_top;
  localparam int NDED = 10;
  localparam int NMC  = 10;
  localparam int NSIG = NDED + NMC;
  localparam int NCOL = 2 * NSIG;
  localparam int NROW = NMC * 8;
  localparam int CFGN = NROW * NCOL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgEn = 1'b0;
  logic cfgBit = 1'b0;
  logic [NDED-1:0] dedIn = '0;
  logic [NMC-1:0] ioIn = '0;
  logic oeN = 1'b0;
  logic preloadN = 1'b1;
  logic [NMC-1:0] ioOut;
  logic [NMC-1:0] ioOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "R11";

  bit cfgM [CFGN];
  bit img  [CFGN];
  bit qM   [NMC];
  bit cpM  [NMC];
  bit opM  [NMC];

  always #2.5 clk = ~clk;

  sopMacroArray dut_i (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgBit(cfgBit), .dedIn(dedIn),
    .ioIn(ioIn), .oeN(oeN), .preloadN(preloadN), .ioOut(ioOut), .ioOe(ioOe)
  );

  function automatic bit colVal(int c);
    int s = c / 2;
    bit v;
    if (s < NDED) v = dedIn[s];
    else v = opM[s-NDED] ? !qM[s-NDED] : ioIn[s-NDED];
    return (c % 2 == 1) ? !v : v;
  endfunction

  task automatic tick();
    bit termV [NROW];
    bit nq [NMC];
    bit ncp [NMC];
    bit ncfg [CFGN];
    logic [NMC-1:0] expOe;
    logic [NMC-1:0] expOut;
    #1;
    for (int r = 0; r < NROW; r++) begin
      termV[r] = 1;
      for (int c = 0; c < NCOL; c++)
        if (cfgM[r*NCOL+c] && !colVal(c)) termV[r] = 0;
    end
    for (int m = 0; m < NMC; m++) begin
      int b = 8 * m;
      bit ds, rt, pt, ct, ot;
      ds = termV[b] | termV[b+1] | termV[b+2] | termV[b+3];
      rt = termV[b+4]; pt = termV[b+5]; ct = termV[b+6]; ot = termV[b+7];
      expOe[m]  = ot && !oeN && !cfgEn && !rst;
      expOut[m] = (rt && pt) ? !ds : !qM[m];
      nq[m] = qM[m];
      if (rst) begin nq[m] = 0; ncp[m] = 1; end
      else if (cfgEn) ncp[m] = 1;
      else begin
        ncp[m] = ct;
        if (!preloadN) begin if (!expOe[m]) nq[m] = !ioIn[m]; end
        else if (rt && pt) nq[m] = qM[m];
        else if (rt) nq[m] = 0;
        else if (pt) nq[m] = 1;
        else if (ct && !cpM[m]) nq[m] = ds;
      end
    end
    for (int i = 0; i < CFGN; i++) begin
      if (rst) ncfg[i] = 0;
      else if (cfgEn) ncfg[i] = (i == CFGN-1) ? cfgBit : cfgM[i+1];
      else ncfg[i] = cfgM[i];
    end
    checks++;
    if (ioOe !== expOe) begin
      errors++;
      $display("FAIL %s ioOe actual=%b expected=%b", curTag, ioOe, expOe);
    end
    if (!rst) begin
      checks++;
      if (ioOut !== expOut) begin
        errors++;
        $display("FAIL %s ioOut actual=%b expected=%b", curTag, ioOut, expOut);
      end
    end
    @(posedge clk);
    for (int m = 0; m < NMC; m++) begin qM[m] = nq[m]; cpM[m] = ncp[m]; opM[m] = expOe[m]; end
    for (int i = 0; i < CFGN; i++) cfgM[i] = ncfg[i];
    #1;
  endtask

  task automatic setLit(int row, int sig, bit neg);
    img[row*NCOL + 2*sig + neg] = 1;
  endtask

  task automatic zeroRow(int row);
    setLit(row, 0, 0);
    setLit(row, 0, 1);
  endtask

  task automatic loadImg();
    curTag = "R10";
    cfgEn = 1;
    for (int k = 0; k < CFGN; k++) begin
      cfgBit = img[k];
      tick();
    end
    cfgEn = 0;
    cfgBit = 0;
  endtask

  task automatic randomRun(int n, string tag);
    curTag = tag;
    for (int i = 0; i < n; i++) begin
      dedIn    = NDED'($urandom);
      ioIn     = NMC'($urandom);
      oeN      = ($urandom % 8) == 0;
      preloadN = ($urandom % 16) != 0;
      tick();
    end
    preloadN = 1;
    oeN = 0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired before the run completed");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < CFGN; i++) cfgM[i] = 0;
    for (int m = 0; m < NMC; m++) begin qM[m] = 0; cpM[m] = 1; opM[m] = 0; end
    #1;
    // R11: no drive while reset is held
    curTag = "R11";
    tick(); tick();
    rst = 0;
    // R3: cleared array, every term true -> bypass with data 1, enables on
    curTag = "R3";
    tick();
    dedIn = 10'h2A5; ioIn = 10'h133;
    tick();
    // R8: shared enable high silences all pins
    curTag = "R8";
    oeN = 1; tick(); oeN = 0;

    // equation set A: controls from dedicated inputs
    for (int i = 0; i < CFGN; i++) img[i] = 0;
    for (int m = 0; m < NMC; m++) begin
      int b = 8 * m;
      setLit(b, m, 0); setLit(b, (m + 1) % NDED, 1);
      setLit(b+1, NDED + (m + 3) % NMC, 0);
      zeroRow(b+2); zeroRow(b+3);
      setLit(b+4, 8, 0);
      setLit(b+5, 9, 0);
      setLit(b+6, 7, 0);
      if (m % 2 == 0) setLit(b+7, 6, 1); else zeroRow(b+7);
    end
    dedIn = '0; ioIn = '0;
    loadImg();

    curTag = "R6";
    dedIn = 10'b01_0000_0000; tick(); tick();
    dedIn = 10'b10_0000_0000; tick(); tick();
    curTag = "R7";
    dedIn = 10'b11_0000_0001; tick();
    dedIn = 10'b11_0000_0110; ioIn = 10'h3FF; tick();
    dedIn = 10'b11_0101_0101; tick();
    curTag = "R5";
    dedIn = 10'b00_0000_0101; ioIn = '0; tick();
    dedIn = 10'b00_1000_0101; tick();
    dedIn = 10'b00_1000_1010; tick();
    dedIn = 10'b00_0000_1010; tick();
    dedIn = 10'b00_1000_1010; tick(); tick();
    curTag = "R9";
    oeN = 1; preloadN = 0; ioIn = 10'b10_1100_1010; tick();
    preloadN = 1; oeN = 0; tick();
    preloadN = 0; ioIn = 10'b01_0011_0101; tick();
    preloadN = 0; dedIn = 10'b01_0000_0000; tick();
    preloadN = 1; dedIn = '0; tick();
    curTag = "R8";
    dedIn = 10'b00_0100_0000; tick();
    oeN = 1; dedIn = '0; tick(); oeN = 0; tick();
    randomRun(1500, "R1/R2/R3/R4");

    // equation set B: clocks and data from pin feedback
    for (int i = 0; i < CFGN; i++) img[i] = 0;
    for (int m = 0; m < NMC; m++) begin
      int b = 8 * m;
      setLit(b, NDED + m, 1);
      zeroRow(b+1); zeroRow(b+2); zeroRow(b+3);
      setLit(b+4, 0, 0); setLit(b+4, 1, 0);
      setLit(b+5, 0, 0); setLit(b+5, 1, 1);
      if (m == 0) setLit(b+6, 3, 0); else setLit(b+6, NDED + m - 1, 0);
      setLit(b+7, 2, 0);
    end
    dedIn = '0;
    loadImg();
    curTag = "R2/R5";
    dedIn = 10'b00_0000_0100; tick();
    for (int i = 0; i < 40; i++) begin
      dedIn[3] = ~dedIn[3];
      tick();
    end
    randomRun(1500, "R2/R5");

    // R11: reset mid-run clears array and state
    curTag = "R11";
    rst = 1; tick(); tick();
    rst = 0;
    curTag = "R3";
    dedIn = 10'h155; tick(); tick();
    finished = 1;
    finishRun();
  end
endmodule